// File: doc/BRIEF.md
# Ratio-Clocked FIFO

A first-in first-out buffer that carries words from a write clock domain to a read clock domain. Both clocks come from one source, and one frequency is an integer multiple of the other. The rising edges of the slower clock always coincide with rising edges of the faster one. Because of this, each side can read the other side's pointer without gray coding or synchroniser flops. There is no metastability protection, and none is needed as long as the clock relation holds. The block does not support truly asynchronous clock pairs.

The side with the faster or equal clock uses the other side's pointer directly. The slower side takes a registered copy on its own edge. The slower side's status flags are therefore late but never optimistic: full and empty may assert early or release late, but never the reverse. Data, write enable and read enable must be stable relative to the faster clock. The read port is first-word fall-through. Two parameters give the write and read frequency multiples. Two more give the depth, which need not be a power of two, and the data width. A single active-low reset clears both sides.

Top module: `ratio_fifo`

## Requirements
- R1: While empty_o is low, rdata_o shows the oldest unread word. A read-clock edge with ren_i high and empty_o low moves rdata_o to the next word, and words leave in the order they were accepted.
- R2: With no reads, full_o goes high right after the DEPTH-th accepted write. A write while full_o is high stores nothing, so the stored count never exceeds DEPTH and no extra word appears on the read side.
- R3: A read while empty_o is high has no effect. empty_o stays high, and the next word written is the next word read.
- R4: one_free_o is high exactly when the write side's count is DEPTH-1. That count is exact while no reads are outstanding. one_free_o never claims a free slot that is not there.
- R5: one_word_o is high exactly when the read side's count is 1. That count is exact once writes have settled. one_word_o is never high when nothing is stored.
- R6: During and right after reset: empty_o=1, full_o=0, one_word_o=0, and one_free_o=1 only when DEPTH is 1.
- R7: Flags are conservative. empty_o is never low while nothing is stored, and full_o is never low while DEPTH words are stored.
- R8: An accepted write makes empty_o low no later than the first read-clock rising edge strictly after the write edge. An accepted read makes full_o low no later than the first write-clock rising edge strictly after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock, integer-related to wclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| wdata_i | input | WIDTH | Write data |
| wen_i | input | 1 | Write enable |
| full_o | output | 1 | No free slot (write side view) |
| one_free_o | output | 1 | Exactly one free slot (write side view) |
| ren_i | input | 1 | Read enable |
| rdata_o | output | WIDTH | Oldest stored word (fall-through) |
| empty_o | output | 1 | Nothing stored (read side view) |
| one_word_o | output | 1 | Exactly one word stored (read side view) |

## Verification
The bench runs four clock ratios (1:1, 1:2, 2:1, 1:3), including depths of 1 and non-powers of two. A pointer wrap bug at an odd depth would show up as reordered or repeated words. A write accepted while full would later surface as a surplus word after the drain. A read accepted while empty would corrupt the count so that empty_o drops with no data behind it. Each cycle the bench compares the flags with the count it derives from accepted port handshakes: an optimistic flag, such as a slow side using a pointer copy taken one edge too early, is caught as a flag release with the buffer still empty or full. Latency checks place the action on an edge shared by both clocks. A copy that is never refreshed, or one that lags by an extra slow edge, then misses the bound.

// File: rtl/ratio_fifo_pkg.sv
package ratio_fifo_pkg;

  // pointers run over 0 .. 2*depth-1; difference gives the stored count
  function automatic int fill_level(int wr_pos, int rd_pos, int depth);
    return (wr_pos >= rd_pos) ? wr_pos - rd_pos : wr_pos + 2 * depth - rd_pos;
  endfunction

endpackage

// File: rtl/ratio_fifo_mem.sv
module ratio_fifo_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ratio_fifo_wr.sv
module ratio_fifo_wr #(
  parameter int DEPTH = 8,
  parameter int PW    = 4,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [PW-1:0] rptr_i,
  output logic [PW-1:0] wptr_o,
  output logic [AW-1:0] waddr_o,
  output logic          push_o,
  output logic          full_o,
  output logic          one_free_o
);

  logic [PW-1:0] wptr_q;
  logic [CW-1:0] level;

  assign level      = CW'(ratio_fifo_pkg::fill_level(int'(wptr_q), int'(rptr_i), DEPTH));
  assign full_o     = (level == CW'(DEPTH));
  assign one_free_o = (level == CW'(DEPTH - 1));
  assign push_o     = wen_i & ~full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
    end else if (push_o) begin
      wptr_q <= (wptr_q == PW'(2 * DEPTH - 1)) ? '0 : wptr_q + PW'(1);
    end
  end

  assign wptr_o  = wptr_q;
  assign waddr_o = (wptr_q >= PW'(DEPTH)) ? AW'(wptr_q - PW'(DEPTH)) : AW'(wptr_q);

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && full_o) |=> $stable(wptr_q)); // R2

endmodule

// File: rtl/ratio_fifo_rd.sv
module ratio_fifo_rd #(
  parameter int DEPTH = 8,
  parameter int PW    = 4,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_i,
  input  logic [PW-1:0] wptr_i,
  output logic [PW-1:0] rptr_o,
  output logic [AW-1:0] raddr_o,
  output logic          empty_o,
  output logic          one_word_o
);

  logic [PW-1:0] rptr_q;
  logic [CW-1:0] level;
  logic          pop;

  assign level      = CW'(ratio_fifo_pkg::fill_level(int'(wptr_i), int'(rptr_q), DEPTH));
  assign empty_o    = (level == '0);
  assign one_word_o = (level == CW'(1));
  assign pop        = ren_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
    end else if (pop) begin
      rptr_q <= (rptr_q == PW'(2 * DEPTH - 1)) ? '0 : rptr_q + PW'(1);
    end
  end

  assign rptr_o  = rptr_q;
  assign raddr_o = (rptr_q >= PW'(DEPTH)) ? AW'(rptr_q - PW'(DEPTH)) : AW'(rptr_q);

  AST_EMPTY_BLOCKS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_i && empty_o) |=> $stable(rptr_q)); // R3

endmodule

// File: rtl/ratio_fifo.sv
module ratio_fifo #(
  parameter int WR_MULT = 1,
  parameter int RD_MULT = 1,
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 8
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             wen_i,
  output logic             full_o,
  output logic             one_free_o,
  input  logic             ren_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             one_word_o
);

  localparam int PW = $clog2(2 * DEPTH);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit WR_SLOW = (WR_MULT < RD_MULT);
  localparam bit RD_SLOW = (RD_MULT < WR_MULT);

  logic [PW-1:0] wptr, rptr, rptr_wview, wptr_rview;
  logic [AW-1:0] waddr, raddr;
  logic          push;

  // slower side keeps a copy taken on its own edge; faster side reads directly
  if (WR_SLOW) begin : g_wview
    always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni) rptr_wview <= '0;
      else         rptr_wview <= rptr;
    end
  end else begin : g_wview
    assign rptr_wview = rptr;
  end

  if (RD_SLOW) begin : g_rview
    always_ff @(posedge rclk_i or negedge rst_ni) begin
      if (!rst_ni) wptr_rview <= '0;
      else         wptr_rview <= wptr;
    end
  end else begin : g_rview
    assign wptr_rview = wptr;
  end

  ratio_fifo_wr #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .CW(CW)) u_wr (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .wen_i      (wen_i),
    .rptr_i     (rptr_wview),
    .wptr_o     (wptr),
    .waddr_o    (waddr),
    .push_o     (push),
    .full_o     (full_o),
    .one_free_o (one_free_o)
  );

  ratio_fifo_rd #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .CW(CW)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .ren_i      (ren_i),
    .wptr_i     (wptr_rview),
    .rptr_o     (rptr),
    .raddr_o    (raddr),
    .empty_o    (empty_o),
    .one_word_o (one_word_o)
  );

  ratio_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk_i   (wclk_i),
    .we_i    (push),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );

  // true stored count from the live pointers of both sides
  logic [CW-1:0] true_level;
  assign true_level = CW'(ratio_fifo_pkg::fill_level(int'(wptr), int'(rptr), DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    true_level <= CW'(DEPTH)); // R2
  AST_FULL_SAFE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (true_level == CW'(DEPTH)) |-> full_o); // R7
  AST_EMPTY_SAFE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (true_level == '0) |-> empty_o); // R7
  AST_ONE_FREE_SAFE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    one_free_o |-> (true_level <= CW'(DEPTH - 1))); // R4
  AST_ONE_WORD_SAFE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    one_word_o |-> (true_level != '0)); // R5

endmodule

// File: tb/ratio_fifo_tb_unit.sv
module ratio_fifo_tb_unit #(
  parameter int WM    = 1,
  parameter int RM    = 1,
  parameter int DEPTH = 4
);
  localparam int FAST = (WM > RM) ? WM : RM;
  localparam int WDIV = FAST / WM;
  localparam int RDIV = FAST / RM;

  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic        wen = 1'b0, ren = 1'b0;
  logic [15:0] wdata = '0;
  logic        full, one_free, empty, one_word;
  logic [15:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int hc     = 0;
  int wr_done = 0;
  int rd_done = 0;
  logic [15:0] q[$];

  // fastest clock: 8 ns period (125 MHz); rising edges aligned at slow edges
  always begin
    #4;
    wclk = ((hc / WDIV) % 2) == 0;
    rclk = ((hc / RDIV) % 2) == 0;
    hc++;
  end

  ratio_fifo #(.WR_MULT(WM), .RD_MULT(RM), .DEPTH(DEPTH), .WIDTH(16)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wdata_i(wdata), .wen_i(wen), .full_o(full), .one_free_o(one_free),
    .ren_i(ren), .rdata_o(rdata), .empty_o(empty), .one_word_o(one_word)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ratio %0d:%0d depth %0d act=%0h exp=%0h", req, WM, RM, DEPTH, act, exp);
    end
  endfunction

  always @(posedge wclk) if (rst_n && wen && !full) wr_done++;
  always @(posedge rclk) if (rst_n && ren && !empty) rd_done++;

  // R7: conservative flags versus the count of accepted handshakes
  always @(posedge rclk) begin
    #1;
    if (rst_n) chk(empty || (wr_done - rd_done) > 0, "R7 empty", int'(empty), 1);
  end
  always @(posedge wclk) begin
    #1;
    if (rst_n) chk(full || (wr_done - rd_done) < DEPTH, "R7 full", int'(full), 1);
  end

  task automatic wsync(); @(posedge wclk); #1; endtask
  task automatic rsync(); @(posedge rclk); #1; endtask

  task automatic settle();
    repeat (3) begin @(posedge wclk); @(posedge rclk); end
    #1;
  endtask

  task automatic push(input logic [15:0] d);
    while (full) wsync();
    wen = 1'b1; wdata = d; q.push_back(d);
    wsync();
    wen = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [15:0] exp;
    while (empty) rsync();
    if (q.size() == 0) begin
      chk(1'b0, req, int'(rdata), 0);
    end else begin
      exp = q.pop_front();
      chk(rdata == exp, req, int'(rdata), int'(exp));
    end
    ren = 1'b1;
    rsync();
    ren = 1'b0;
  endtask

  task automatic t_reset();
    repeat (4) rsync();
    chk(empty == 1'b1, "R6 empty", int'(empty), 1);
    chk(full == 1'b0, "R6 full", int'(full), 0);
    chk(one_word == 1'b0, "R6 one_word", int'(one_word), 0);
    chk(one_free == (DEPTH == 1), "R6 one_free", int'(one_free), int'(DEPTH == 1));
    rst_n = 1'b1;
    settle();
    chk(empty == 1'b1 && full == 1'b0, "R6 after release", int'({empty, full}), 2);
  endtask

  task automatic t_fill_overflow();
    wsync();
    for (int k = 0; k < DEPTH; k++) begin
      chk(full == 1'b0, "R2 not full early", int'(full), 0);
      push(16'(16'h1000 + k));
      chk(one_free == (k + 1 == DEPTH - 1), "R4", int'(one_free), int'(k + 1 == DEPTH - 1));
    end
    chk(full == 1'b1, "R2 full at depth", int'(full), 1);
    wen = 1'b1; wdata = 16'hdead;
    repeat (3) wsync();
    wen = 1'b0;
    chk(full == 1'b1, "R2 full held", int'(full), 1);
    settle();
    for (int k = 0; k < DEPTH; k++) begin
      chk(one_word == (DEPTH - k == 1), "R5", int'(one_word), int'(DEPTH - k == 1));
      pop_check("R1 fill drain");
    end
    settle();
    chk(empty == 1'b1, "R2 no extra word", int'(empty), 1);
    chk(one_word == 1'b0, "R5 after drain", int'(one_word), 0);
  endtask

  task automatic t_underflow();
    rsync();
    ren = 1'b1;
    repeat (3) rsync();
    ren = 1'b0;
    chk(empty == 1'b1, "R3 still empty", int'(empty), 1);
    wsync();
    push(16'h5a5a);
    pop_check("R3 next word");
    settle();
    chk(empty == 1'b1, "R3 empty again", int'(empty), 1);
  endtask

  task automatic t_latency();
    wsync();
    wen = 1'b1; wdata = 16'h7e57; q.push_back(16'h7e57);
    @(posedge wclk);
    #1;
    wen = 1'b0;
    if (empty) begin
      @(posedge rclk);
      #1;
    end
    chk(empty == 1'b0, "R8 empty release", int'(empty), 0);
    rsync();
    pop_check("R1 latency word");
    wsync();
    for (int k = 0; k < DEPTH; k++) push(16'(16'h2000 + k));
    settle();
    chk(full == 1'b1, "R2 full before read", int'(full), 1);
    pop_check("R1 first of full");
    if (full) begin
      @(posedge wclk);
      #1;
    end
    chk(full == 1'b0, "R8 full release", int'(full), 0);
    rsync();
    for (int k = 1; k < DEPTH; k++) pop_check("R1 rest of full");
    settle();
  endtask

  task automatic t_stream();
    fork
      begin
        wsync();
        for (int i = 0; i < 40; i++) begin
          push(16'(i * 37 + 5));
          if (i % 4 == 1) wsync();
        end
      end
      begin
        rsync();
        for (int i = 0; i < 40; i++) begin
          pop_check("R1 stream");
          if (i % 3 == 0) repeat (2) rsync();
        end
      end
    join
    settle();
    chk(empty == 1'b1, "R1 stream drained", int'(empty), 1);
  endtask

  initial begin
    t_reset();
    t_fill_overflow();
    t_underflow();
    t_latency();
    t_stream();
    done = 1'b1;
  end

endmodule

// File: tb/ratio_fifo_tb_top.sv
module ratio_fifo_tb_top;

  ratio_fifo_tb_unit #(.WM(1), .RM(1), .DEPTH(4)) u_r11 ();
  ratio_fifo_tb_unit #(.WM(1), .RM(2), .DEPTH(3)) u_r12 ();
  ratio_fifo_tb_unit #(.WM(2), .RM(1), .DEPTH(5)) u_r21 ();
  ratio_fifo_tb_unit #(.WM(1), .RM(3), .DEPTH(1)) u_r13 ();

  initial begin
    int errs;
    int cks;
    bit timed_out;
    timed_out = 1'b0;
    fork
      wait (u_r11.done && u_r12.done && u_r21.done && u_r13.done);
      begin
        #1500000;
        timed_out = 1'b1;
      end
    join_any
    errs = u_r11.errors + u_r12.errors + u_r21.errors + u_r13.errors;
    cks  = u_r11.checks + u_r12.checks + u_r21.checks + u_r13.checks;
    if (timed_out) begin
      errs++;
      cks++;
      $display("FAIL watchdog: run did not complete act=0 exp=1");
    end
    $display("Result: errors=%0d of %0d checks", errs, cks);
    $finish;
  end

endmodule